// File: doc/BRIEF.md
# Debounced Power-On Reset Controller

This block produces the active-low system reset for a single clock domain. Reset is driven low at once whenever the raw external reset input is low, with no clock needed. After that input goes high, the block waits a fixed number of clock cycles so that supplies and oscillators can settle. It then releases the system reset through a two-stage flop chain, so that the rising edge of the reset is aligned to the clock.

A manual reset key can also start a new reset. The raw key level first passes through two synchroniser flops. A prescaler then samples it only once per sample period, so contact bounce that dies out between two sample instants has no effect. A press is recognised when one sample is high and the next sample is low. A press clears the settling counter, which pulls the system reset low. The full settling interval then runs again before the same two-flop release takes place.

Top module: `por_reset_ctrl`

## Requirements
- R1: Counting the rising clock edges after `ext_rst_n` goes high as edge 1, 2, …, `sys_rst_n` stays 0 through edge SETTLE_CYCLES+1 and becomes 1 at edge SETTLE_CYCLES+2, provided no key press occurs.
- R2: A low level on `ext_rst_n` drives `sys_rst_n` to 0 immediately, without waiting for a clock edge, and it stays 0 while `ext_rst_n` is low.
- R3: The settling counter stops at its terminal value SETTLE_CYCLES instead of wrapping, so once released, `sys_rst_n` stays 1 for as long as no press and no external reset occur.
- R4: Release goes through two flops in series. `sys_rst_n` rises only after the counter has been at its terminal value for two consecutive edges.
- R5: While the settling counter is below its terminal value, both release flops are held at 0, so `sys_rst_n` is 0.
- R6: The synchronised key level is sampled only on edges whose number (counted as in R1) is a multiple of SAMPLE_CYCLES. A key level must be present before edge n−2 to be seen by the sample taken at edge n. A low pulse that does not cover any sample instant has no effect.
- R7: A press is a high sample followed by a low sample. Holding the key low across many samples gives exactly one press, and a low-to-high key change gives none.
- R8: If a press is sampled at edge m, `sys_rst_n` is 0 after edge m+1. It becomes 1 at edge m+SETTLE_CYCLES+3, whether the press happens during settling or after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | Raw asynchronous external reset, active low |
| key_raw | input | 1 | Raw manual reset key level, low while pressed |
| sys_rst_n | output | 1 | Synchronised system reset, active low |

## Verification
A counter that is off by one, or a missing stage in the release chain, moves the rising edge of `sys_rst_n` by a whole cycle. The bench checks that edge at the exact cycle, both after an external reset and after a press. A sampler that runs too often, or that catches the wrong edge, shows up within one sample period as an extra or missing drop of `sys_rst_n` after a glitch, a bounce, a long hold or a key release. A counter that wraps pulls the reset low again SETTLE_CYCLES cycles after release, which the long hold-high windows catch.

// File: rtl/por_pkg.sv
package por_pkg;

    typedef struct packed {
        logic meta;
        logic sync;
        logic smp;
        logic press;
    } key_st_t;

    typedef struct packed {
        logic stg0;
        logic stg1;
    } rel_st_t;

    localparam logic KEY_IDLE = 1'b1;

endpackage

// File: rtl/por_prescale.sv
module por_prescale #(
    parameter int SAMPLE_CYCLES = 500_000
) (
    input  logic clk,
    input  logic arst_n,
    output logic tick
);
    localparam int PRE_W = (SAMPLE_CYCLES > 1) ? $clog2(SAMPLE_CYCLES) : 1;
    localparam logic [PRE_W-1:0] LAST = PRE_W'(SAMPLE_CYCLES - 1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = (st_q.cnt == LAST);
endmodule

// File: rtl/por_key_press.sv
module por_key_press
    import por_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic key_raw,
    input  logic tick,
    output logic press
);
    key_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.meta  = key_raw;
        st_d.sync  = st_q.meta;
        st_d.press = 1'b0;
        if (tick) begin
            st_d.smp   = st_q.sync;
            st_d.press = st_q.smp & ~st_q.sync;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q.meta  <= KEY_IDLE;
            st_q.sync  <= KEY_IDLE;
            st_q.smp   <= KEY_IDLE;
            st_q.press <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign press = st_q.press;
endmodule

// File: rtl/por_settle.sv
module por_settle #(
    parameter int SETTLE_CYCLES = 5_000_000
) (
    input  logic                                  clk,
    input  logic                                  arst_n,
    input  logic                                  restart,
    output logic [$clog2(SETTLE_CYCLES+1)-1:0]    cnt,
    output logic                                  settled
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] TERM = CNT_W'(SETTLE_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else if (st_q.cnt < TERM) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt     = st_q.cnt;
    assign settled = (st_q.cnt == TERM) & ~restart;
endmodule

// File: rtl/por_release_sync.sv
module por_release_sync
    import por_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic settled,
    output logic rst_n_out
);
    rel_st_t st_d, st_q;

    always_comb begin
        if (settled) begin
            st_d.stg0 = 1'b1;
            st_d.stg1 = st_q.stg0;
        end else begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_n_out = st_q.stg1;
endmodule

// File: rtl/por_reset_ctrl.sv
module por_reset_ctrl #(
    parameter int SETTLE_CYCLES = 5_000_000,
    parameter int SAMPLE_CYCLES = 500_000
) (
    input  logic clk,
    input  logic ext_rst_n,
    input  logic key_raw,
    output logic sys_rst_n
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);

    logic             sample_tick;
    logic             key_press;
    logic             settled;
    logic [CNT_W-1:0] settle_cnt;

    por_prescale #(.SAMPLE_CYCLES(SAMPLE_CYCLES)) u_pre (
        .clk    (clk),
        .arst_n (ext_rst_n),
        .tick   (sample_tick)
    );

    por_key_press u_key (
        .clk     (clk),
        .arst_n  (ext_rst_n),
        .key_raw (key_raw),
        .tick    (sample_tick),
        .press   (key_press)
    );

    por_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk     (clk),
        .arst_n  (ext_rst_n),
        .restart (key_press),
        .cnt     (settle_cnt),
        .settled (settled)
    );

    por_release_sync u_rel (
        .clk       (clk),
        .arst_n    (ext_rst_n),
        .settled   (settled),
        .rst_n_out (sys_rst_n)
    );
endmodule

// File: rtl/por_reset_chk.sv
module por_reset_chk #(
    parameter int SETTLE_CYCLES = 5_000_000
) (
    input logic                               clk,
    input logic                               ext_rst_n,
    input logic                               sys_rst_n,
    input logic [$clog2(SETTLE_CYCLES+1)-1:0] cnt,
    input logic                               settled,
    input logic                               press,
    input logic                               tick
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] TERM = CNT_W'(SETTLE_CYCLES);

    a_r3_saturate: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (cnt == TERM && !press) |=> (cnt == TERM));

    a_r3_step: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (cnt < TERM && !press) |=> (cnt == $past(cnt) + 1'b1));

    a_r4_two_stage: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $rose(sys_rst_n) |-> ($past(settled) && $past(settled, 2)));

    a_r5_forced_low: assert property (@(posedge clk) disable iff (!ext_rst_n)
        !settled |=> !sys_rst_n);

    a_r6_tick_single: assert property (@(posedge clk) disable iff (!ext_rst_n)
        tick |=> !tick);

    a_r7_press_on_sample: assert property (@(posedge clk) disable iff (!ext_rst_n)
        press |-> $past(tick));

    a_r7_press_single: assert property (@(posedge clk) disable iff (!ext_rst_n)
        press |=> !press);

    a_r8_restart: assert property (@(posedge clk) disable iff (!ext_rst_n)
        press |=> (cnt == '0));
endmodule

bind por_reset_ctrl por_reset_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_chk (
    .clk       (clk),
    .ext_rst_n (ext_rst_n),
    .sys_rst_n (sys_rst_n),
    .cnt       (settle_cnt),
    .settled   (settled),
    .press     (key_press),
    .tick      (sample_tick)
);

// File: tb/test_por_reset_ctrl.sv
module test_por_reset_ctrl;
    localparam int SETTLE = 40;
    localparam int SAMPLE = 8;

    logic clk = 1'b0;
    logic ext_rst_n = 1'b0;
    logic key_raw = 1'b1;
    logic sys_rst_n;
    int   edge_n = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) edge_n <= 0;
        else            edge_n <= edge_n + 1;
    end

    por_reset_ctrl #(.SETTLE_CYCLES(SETTLE), .SAMPLE_CYCLES(SAMPLE)) i_por_reset_ctrl (
        .clk       (clk),
        .ext_rst_n (ext_rst_n),
        .key_raw   (key_raw),
        .sys_rst_n (sys_rst_n)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at edge %0d: actual %b expected %b", tag, edge_n, act, exp);
        end
    endtask

    task automatic go_edge(input int target);
        while (edge_n < target) @(negedge clk);
    endtask

    task automatic check_at(input int target, input logic exp, input string tag);
        go_edge(target);
        check(sys_rst_n, exp, tag);
    endtask

    task automatic hold_high(input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check(sys_rst_n, 1'b1, tag);
        end
    endtask

    function automatic int sample_edge(input int j);
        return ((j + 3 + SAMPLE - 1) / SAMPLE) * SAMPLE;
    endfunction

    task automatic release_ext();
        @(negedge clk);
        ext_rst_n = 1'b1;
    endtask

    task automatic t_power_up();
        #1;
        check(sys_rst_n, 1'b0, "R2 reset state");
        repeat (3) @(negedge clk);
        check(sys_rst_n, 1'b0, "R2 held while low");
        release_ext();
        check_at(SETTLE, 1'b0, "R5 below terminal");
        check_at(SETTLE + 1, 1'b0, "R4 first stage only");
        check_at(SETTLE + 2, 1'b1, "R1 release edge");
        hold_high(SETTLE + 3 * SAMPLE, "R3 no wrap");
    endtask

    task automatic t_async_reset();
        @(negedge clk);
        #1 ext_rst_n = 1'b0;
        #0.5;
        check(sys_rst_n, 1'b0, "R2 async assert");
        repeat (2) @(negedge clk);
        check(sys_rst_n, 1'b0, "R2 held low");
        release_ext();
        check_at(SETTLE + 1, 1'b0, "R1 before release");
        check_at(SETTLE + 2, 1'b1, "R1 after async reset");
    endtask

    task automatic t_glitch();
        while (edge_n % SAMPLE != 1) @(negedge clk);
        key_raw = 1'b0;
        @(negedge clk);
        @(negedge clk);
        key_raw = 1'b1;
        hold_high(3 * SAMPLE, "R6 glitch ignored");
    endtask

    task automatic t_bounce_press();
        int j, m;
        while (edge_n % SAMPLE != 1) @(negedge clk);
        key_raw = 1'b0; @(negedge clk);
        key_raw = 1'b1; @(negedge clk);
        key_raw = 1'b0; @(negedge clk);
        key_raw = 1'b1; @(negedge clk);
        key_raw = 1'b0;
        j = edge_n;
        m = sample_edge(j);
        check_at(m, 1'b1, "R6 not yet sampled");
        check_at(m + 1, 1'b0, "R8 press asserts reset");
        check_at(m + SETTLE + 2, 1'b0, "R8 still held");
        check_at(m + SETTLE + 3, 1'b1, "R8 restart release");
        hold_high(4 * SAMPLE, "R7 held key single press");
        key_raw = 1'b1;
        hold_high(4 * SAMPLE, "R7 key release ignored");
    endtask

    task automatic t_press_during_settle();
        int m;
        @(negedge clk);
        ext_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        release_ext();
        go_edge(10);
        key_raw = 1'b0;
        m = sample_edge(10);
        check_at(SETTLE + 2, 1'b0, "R5 restarted count still low");
        check_at(m + SETTLE + 2, 1'b0, "R8 settle press held");
        check_at(m + SETTLE + 3, 1'b1, "R8 settle press release");
        key_raw = 1'b1;
        hold_high(3 * SAMPLE, "R7 release after settle press");
    endtask

    initial begin
        t_power_up();
        t_glitch();
        t_bounce_press();
        t_async_reset();
        t_press_during_settle();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule